// File: doc/BRIEF.md
# Instruction Line-Fill Read Receiver

This block collects the instruction words that a bus slave returns during an instruction-fetch read and places them in a line buffer of up to eight words. When a fetch starts, the block captures three things: whether the responding slave is 32 or 64 bits wide, whether the fetch is cacheable, and a request-size control bit that applies to non-cacheable fetches. From these it works out the line length and the number of data beats to expect. It then accepts one beat for each cycle in which the read-acknowledge strobe is high.

A narrow slave returns one word per beat, copied onto both halves of the 64-bit bus. A wide slave returns an aligned doubleword per beat. Words fill the buffer in order from word 0. After the final expected beat, the block reports completion with a one-cycle pulse, returns to idle, and holds the buffer steady for reading. It also reports how many words were filled.

The read-data input behaves as a stream with a valid strobe and no ready. The receiver cannot push back on the slave. While a fetch is active it takes every acknowledged beat, and the slave may insert any number of idle cycles between beats. The start, configuration and status pins are plain level or pulse signals.

Top module: `ifetch_line_rx`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `word_count_o` are 0, and all eight words of `line_o` are 0.
- R2: A fetch completes after exactly the following number of acknowledged beats:
  - Narrow slave (`wide_i`=0): 4 beats if non-cacheable with `size_i`=0, otherwise 8 beats.
  - Wide slave (`wide_i`=1): 2 beats if non-cacheable with `size_i`=0, otherwise 4 beats.
- R3: The line length is 4 words when `cacheable_i`=0 and `size_i`=0, and 8 words otherwise. `word_count_o` holds 0 while a fetch is busy and shows the line length from the completing edge onward.
- R4: A narrow-slave beat writes `rd_data_i[63:32]` into word k of the line, where k counts the beats of the fetch from 0. `rd_data_i[31:0]` is ignored. Word i of the line is `line_o[32*i +: 32]`.
- R5: Beat k from a wide slave writes `rd_data_i[63:32]` into word 2k and `rd_data_i[31:0]` into word 2k+1.
- R6: In cycles where `rd_valid_i`=0, `rd_data_i` is ignored. Any number of such cycles may fall between beats without changing the result.
- R7: While no fetch is active, `rd_valid_i` pulses change neither the line nor `word_count_o`.
- R8: `wide_i`, `cacheable_i` and `size_i` are sampled on the clock edge where `start_i` is accepted. Changes to them during the fetch have no effect.
- R9: A `start_i` pulse while `busy_o`=1 is ignored. The running fetch keeps its configuration and its beat count.
- R10: On the clock edge that captures the final beat, `busy_o` falls and `done_o` rises for exactly one cycle.
- R11: In a 4-word fetch, words 4 to 7 keep their previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a fetch when the block is idle |
| wide_i | input | 1 | Slave width: 1 for 64-bit, 0 for 32-bit |
| cacheable_i | input | 1 | The fetch is cacheable |
| size_i | input | 1 | Request-size bit for a non-cacheable fetch: 1 requests eight words |
| rd_valid_i | input | 1 | Read-acknowledge strobe, one cycle per beat |
| rd_data_i | input | 64 | Read data; bits 63:32 are the first (even) word |
| busy_o | output | 1 | A fetch is in progress |
| done_o | output | 1 | One-cycle pulse after the final beat is captured |
| word_count_o | output | 4 | Number of words filled by the last completed fetch |
| line_o | output | 256 | Line buffer; word i is at bits 32*i+31:32*i |

## Verification
The hardest case to reach is the one where the configuration pins, a second start, and junk on the data bus all change in the middle of a fetch. Each of them must leave the beat count and the buffer untouched. The stimulus sweeps every combination of width, cacheability and size bit under three gap patterns. Between beats it inverts the configuration inputs and drives unrelated data with the strobe low. In the long-gap pattern it also pulses start while busy. A 4-word fetch that follows an 8-word fetch shows that the upper words are preserved.

// File: rtl/ifl_pkg.sv
package ifl_pkg;
  typedef struct packed {
    logic wide;
    logic cacheable;
    logic size;
  } fetch_cfg_t;
endpackage

// File: rtl/ifl_beat_planner.sv
module ifl_beat_planner
  import ifl_pkg::*;
#(
  parameter int LINE_WORDS  = 8,
  parameter int SHORT_WORDS = 4,
  parameter int CNT_W       = 4
) (
  input  fetch_cfg_t       cfg_i,
  output logic [CNT_W-1:0] line_len_o,
  output logic [CNT_W-1:0] step_o,
  output logic             pair_o
);
  localparam logic [CNT_W-1:0] FULL_LEN  = CNT_W'(LINE_WORDS);
  localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(SHORT_WORDS);

  // A short line only for non-cacheable fetches with the size bit clear
  always_comb begin
    line_len_o = (cfg_i.cacheable || cfg_i.size) ? FULL_LEN : SHORT_LEN;
    pair_o     = cfg_i.wide;
    step_o     = cfg_i.wide ? CNT_W'(2) : CNT_W'(1);
  end
endmodule

// File: rtl/ifl_fill_tracker.sv
module ifl_fill_tracker
  import ifl_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  fetch_cfg_t       cfg_i,
  input  logic             rd_valid_i,
  input  logic [CNT_W-1:0] line_len_i,
  input  logic [CNT_W-1:0] step_i,
  input  logic             pair_i,
  output fetch_cfg_t       cfg_q_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o,
  output logic             wr_en_o,
  output logic             wr_pair_o,
  output logic [CNT_W-1:0] wr_idx_o
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] idx_q, count_q, next_idx;
  fetch_cfg_t       cfg_q;
  logic             accept, last_beat;

  always_comb begin
    accept    = busy_q && rd_valid_i;
    next_idx  = idx_q + step_i;
    last_beat = accept && (next_idx >= line_len_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      count_q <= '0;
      cfg_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          cfg_q   <= cfg_i;
          idx_q   <= '0;
          count_q <= '0;
        end
      end else if (accept) begin
        idx_q <= next_idx;
        if (last_beat) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          count_q <= line_len_i;
        end
      end
    end
  end

  assign cfg_q_o   = cfg_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign count_o   = count_q;
  assign wr_en_o   = accept;
  assign wr_pair_o = pair_i;
  assign wr_idx_o  = idx_q;
endmodule

// File: rtl/ifl_line_store.sv
module ifl_line_store #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int CNT_W      = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en_i,
  input  logic                         wr_pair_i,
  input  logic [CNT_W-1:0]             wr_idx_i,
  input  logic [2*WORD_W-1:0]          bus_i,
  output logic [LINE_WORDS*WORD_W-1:0] line_o
);
  logic [WORD_W-1:0] hi_word, lo_word;
  logic [CNT_W-1:0]  pair_idx;

  // First (even) word on the upper half; a narrow slave repeats it below
  assign hi_word  = bus_i[2*WORD_W-1:WORD_W];
  assign lo_word  = bus_i[WORD_W-1:0];
  assign pair_idx = wr_idx_i + CNT_W'(1);

  for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
    localparam logic [CNT_W-1:0] SLOT = CNT_W'(i);
    logic              hit;
    logic [WORD_W-1:0] wdata;
    logic [WORD_W-1:0] word_q;

    assign hit = wr_en_i && ((wr_idx_i == SLOT) || (wr_pair_i && (pair_idx == SLOT)));

    if (i % 2 == 1) begin : g_odd
      assign wdata = wr_pair_i ? lo_word : hi_word;
    end else begin : g_even
      assign wdata = hi_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= wdata;
    end

    assign line_o[i*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/ifetch_line_rx.sv
module ifetch_line_rx
  import ifl_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int LINE_WORDS  = 8,
  parameter int SHORT_WORDS = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start_i,
  input  logic                                 wide_i,
  input  logic                                 cacheable_i,
  input  logic                                 size_i,
  input  logic                                 rd_valid_i,
  input  logic [2*WORD_W-1:0]                  rd_data_i,
  output logic                                 busy_o,
  output logic                                 done_o,
  output logic [$clog2(LINE_WORDS+1)-1:0]      word_count_o,
  output logic [LINE_WORDS*WORD_W-1:0]         line_o
);
  localparam int CNT_W = $clog2(LINE_WORDS + 1);

  fetch_cfg_t       cfg_in, cfg_held;
  logic [CNT_W-1:0] line_len, step, wr_idx;
  logic             pair, wr_en, wr_pair;

  assign cfg_in = '{wide: wide_i, cacheable: cacheable_i, size: size_i};

  ifl_beat_planner #(
    .LINE_WORDS (LINE_WORDS),
    .SHORT_WORDS(SHORT_WORDS),
    .CNT_W      (CNT_W)
  ) planner_i (
    .cfg_i     (cfg_held),
    .line_len_o(line_len),
    .step_o    (step),
    .pair_o    (pair)
  );

  ifl_fill_tracker #(.CNT_W(CNT_W)) tracker_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cfg_i     (cfg_in),
    .rd_valid_i(rd_valid_i),
    .line_len_i(line_len),
    .step_i    (step),
    .pair_i    (pair),
    .cfg_q_o   (cfg_held),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .count_o   (word_count_o),
    .wr_en_o   (wr_en),
    .wr_pair_o (wr_pair),
    .wr_idx_o  (wr_idx)
  );

  ifl_line_store #(
    .WORD_W    (WORD_W),
    .LINE_WORDS(LINE_WORDS),
    .CNT_W     (CNT_W)
  ) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en),
    .wr_pair_i(wr_pair),
    .wr_idx_i (wr_idx),
    .bus_i    (rd_data_i),
    .line_o   (line_o)
  );
endmodule

// File: rtl/ifetch_line_rx_chk.sv
module ifetch_line_rx_chk #(
  parameter int WORD_W      = 32,
  parameter int LINE_WORDS  = 8,
  parameter int SHORT_WORDS = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            start_i,
  input logic                            rd_valid_i,
  input logic                            busy_o,
  input logic                            done_o,
  input logic [$clog2(LINE_WORDS+1)-1:0] word_count_o,
  input logic [LINE_WORDS*WORD_W-1:0]    line_o
);
  assert_done_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_busy_ends_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_count_zero_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (word_count_o == '0));

  assert_count_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((word_count_o == LINE_WORDS) || (word_count_o == SHORT_WORDS)));

  assert_idle_line_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(line_o) && !busy_o));

  assert_gap_line_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !rd_valid_i) |=> $stable(line_o));
endmodule

bind ifetch_line_rx ifetch_line_rx_chk #(
  .WORD_W     (WORD_W),
  .LINE_WORDS (LINE_WORDS),
  .SHORT_WORDS(SHORT_WORDS)
) chk_i (.*);

// File: tb/ifetch_line_rx_tb_top.sv
`timescale 1ns/1ps
module ifetch_line_rx_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0, wide_i = 1'b0, cacheable_i = 1'b0, size_i = 1'b0;
  logic         rd_valid_i = 1'b0;
  logic [63:0]  rd_data_i = '0;
  logic         busy_o, done_o;
  logic [3:0]   word_count_o;
  logic [255:0] line_o;

  int unsigned n_vec = 0, n_bad = 0;
  bit          finished = 1'b0;
  logic [31:0] exp_line [8];
  logic [31:0] salt = 32'h1357_9BDF;

  always #4 clk = ~clk;

  ifetch_line_rx dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
    .cacheable_i(cacheable_i), .size_i(size_i), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
    .word_count_o(word_count_o), .line_o(line_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_val(input logic [31:0] s, input int i);
    return {s[15:8], 8'(i), 16'hA5C3 ^ s[31:16]};
  endfunction

  task automatic check_line(input string req);
    for (int i = 0; i < 8; i++)
      check(line_o[32*i +: 32] === exp_line[i], req, 64'(line_o[32*i +: 32]), 64'(exp_line[i]));
  endtask

  task automatic run_fetch(input bit wide, input bit cach, input bit sz, input int gapsel);
    int n_words = (cach || sz) ? 8 : 4;
    int beats   = wide ? n_words / 2 : n_words;
    int gaps;
    salt = salt * 32'd1103515245 + 32'd12345;
    // start is sampled at the next rising edge
    start_i = 1'b1; wide_i = wide; cacheable_i = cach; size_i = sz;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R2 busy after start", 64'(busy_o), 64'd1);
    // R8: configuration pins flipped for the rest of the fetch
    wide_i = ~wide; cacheable_i = ~cach; size_i = ~sz;
    for (int b = 0; b < beats; b++) begin
      gaps = (gapsel == 0) ? 0 : (gapsel == 1) ? ((b * 3 + int'(salt[3:0])) % 4) : (b == 1 ? 20 : 1);
      for (int g = 0; g < gaps; g++) begin
        rd_valid_i = 1'b0;
        rd_data_i  = {salt, ~salt} ^ 64'(g * 7919);   // R6 junk
        start_i    = (gapsel == 2 && g == 3);          // R9 start while busy
        @(negedge clk);
      end
      start_i = 1'b0;
      rd_valid_i = 1'b1;
      if (wide) begin
        rd_data_i = {word_val(salt, 2*b), word_val(salt, 2*b+1)};
        exp_line[2*b]   = word_val(salt, 2*b);
        exp_line[2*b+1] = word_val(salt, 2*b+1);
      end else begin
        rd_data_i = {word_val(salt, b), ~word_val(salt, b)};  // R4 lower half differs
        exp_line[b] = word_val(salt, b);
      end
      @(negedge clk);
      rd_valid_i = 1'b0;
      if (b < beats - 1) begin
        check(busy_o === 1'b1 && done_o === 1'b0, "R2 still busy mid-fetch", {busy_o, done_o}, 2'b10);
      end else begin
        check(done_o === 1'b1 && busy_o === 1'b0, "R10 done on last beat", {busy_o, done_o}, 2'b01);
        check(word_count_o === 4'(n_words), "R3 word count", 64'(word_count_o), 64'(n_words));
      end
    end
    check_line(wide ? "R5 R11 line contents wide" : "R4 R11 line contents narrow");
    @(negedge clk);
    check(done_o === 1'b0, "R10 done lasts one cycle", 64'(done_o), 64'd0);
    // R7: acknowledges while idle
    for (int k = 0; k < 3; k++) begin
      rd_valid_i = 1'b1;
      rd_data_i  = {~salt, salt};
      @(negedge clk);
    end
    rd_valid_i = 1'b0;
    check_line("R7 idle acks ignored");
    check(word_count_o === 4'(n_words) && busy_o === 1'b0, "R7 count held", 64'(word_count_o), 64'(n_words));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) exp_line[i] = '0;
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0, "R1 reset status", {busy_o, done_o}, 0);
    check(word_count_o === 4'd0, "R1 reset count", 64'(word_count_o), 0);
    check_line("R1 reset line");
    rst_n = 1'b1;
    @(negedge clk);
    for (int gs = 0; gs < 3; gs++)
      for (int c = 7; c >= 0; c--)
        run_fetch(c[2], c[1], c[0], gs);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule